// File: doc/BRIEF.md
# Prescaled Reload Interval Timer

This block raises a periodic interrupt from the system clock. Three 16-bit registers control it: a down-counter, a prescale value and a reload period. A prescaler divides the clock by the prescale value plus one. Each time the prescaler completes a division, the counter takes one step. A step taken while the counter is at zero does not decrement. Instead it reloads the counter from the period register and sends a one-cycle interrupt pulse.

Software reaches all three registers through a simple single-cycle read/write bus. A level enable input starts the timer and pauses it. The time between interrupts is (period+1)*(scale+1) clock cycles.

Top module: `reload_timer`

## Requirements
- R1: After reset the count, scale and period registers all read zero and `tick_irq` is low.
- R2: A write with `bus_we` high stores `bus_wdata` into the register chosen by `bus_addr`: 0 selects count, 1 selects scale and 2 selects period. `bus_rdata` returns the chosen register combinationally, and address 3 reads zero.
- R3: While enabled, the count changes only on a step, and a step comes once every scale+1 clock cycles. A step with a nonzero count lowers it by one.
- R4: A scale of zero gives a step on every enabled clock cycle.
- R5: A step taken with the count at zero loads the period value and raises `tick_irq` for exactly the cycle in which the reloaded value is visible. Interrupts are therefore (period+1)*(scale+1) enabled cycles apart.
- R6: With `run_en` low, both the count and the prescaler phase hold. Raising `run_en` again continues from the held values, so the total delay to the next interrupt does not change.
- R7: A write to the count register wins over any step in the same cycle. It restarts the prescaler phase from zero, and no interrupt results from that cycle.
- R8: A write to the scale register applies from the next cycle on. If the prescaler phase has already reached the new scale, a step follows at once.
- R9: `tick_irq` is never raised in a cycle that follows a cycle with `run_en` low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| run_en | input | 1 | Timer enable; low pauses the timer |
| bus_we | input | 1 | Write strobe for the register bus |
| bus_addr | input | 2 | Register select (0 count, 1 scale, 2 period) |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data of the selected register |
| tick_irq | output | 1 | One-cycle interrupt pulse on reload |

## Verification
The bench builds the block with its default 16-bit width and programs small values into the registers. It sweeps every scale from 0 to 3 against every period from 0 to 4. For each pair it checks the delay to the first interrupt, the count on every cycle of a full period, and the position of the next pulse. Because the values are small, the back-to-back pulse case (period and scale both zero) and every prescaler phase can be reached in a few thousand cycles. Directed runs then cover pausing, count-write override at a reload, and shrinking the scale below the current phase.

// File: rtl/reload_timer_pkg.sv
package reload_timer_pkg;
  localparam int ADDR_W = 2;
  typedef enum logic [ADDR_W-1:0] {
    SEL_COUNT  = 2'd0,
    SEL_SCALE  = 2'd1,
    SEL_PERIOD = 2'd2,
    SEL_NONE   = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/reload_timer_prescaler.sv
module reload_timer_prescaler #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run,
  input  logic         restart,
  input  logic [W-1:0] limit,
  output logic [W-1:0] phase,
  output logic         step
);
  logic [W-1:0] phase_q, phase_d;
  logic         phase_ce;

  assign step = run && (phase_q >= limit);

  always_comb begin
    phase_ce = restart || run;
    phase_d  = phase_q;
    if (restart)   phase_d = '0;
    else if (step) phase_d = '0;
    else if (run)  phase_d = phase_q + W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        phase_q <= '0;
    else if (phase_ce) phase_q <= phase_d;
  end

  assign phase = phase_q;
endmodule

// File: rtl/reload_timer_counter.sv
module reload_timer_counter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         step,
  input  logic         load_en,
  input  logic [W-1:0] load_val,
  input  logic [W-1:0] reload_val,
  output logic [W-1:0] count,
  output logic         pulse
);
  logic [W-1:0] cnt_q, cnt_d;
  logic         cnt_ce;
  logic         pulse_q, pulse_d;
  logic         at_zero;

  assign at_zero = (cnt_q == '0);

  always_comb begin
    cnt_ce  = load_en || step;
    cnt_d   = cnt_q;
    pulse_d = 1'b0;
    if (load_en) begin
      cnt_d = load_val;
    end else if (step) begin
      if (at_zero) begin
        cnt_d   = reload_val;
        pulse_d = 1'b1;
      end else begin
        cnt_d = cnt_q - W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_ce) cnt_q <= cnt_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pulse_q <= 1'b0;
    else        pulse_q <= pulse_d;
  end

  assign count = cnt_q;
  assign pulse = pulse_q;
endmodule

// File: rtl/reload_timer_regs.sv
module reload_timer_regs
  import reload_timer_pkg::*;
#(
  parameter int W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [W-1:0]      wdata,
  input  logic [W-1:0]      count_in,
  output logic              count_wr,
  output logic [W-1:0]      scale,
  output logic [W-1:0]      period,
  output logic [W-1:0]      rdata
);
  reg_sel_e     sel;
  logic [W-1:0] scale_q, period_q;
  logic         scale_ce, period_ce;

  assign sel       = reg_sel_e'(addr);
  assign count_wr  = we && (sel == SEL_COUNT);
  assign scale_ce  = we && (sel == SEL_SCALE);
  assign period_ce = we && (sel == SEL_PERIOD);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        scale_q <= '0;
    else if (scale_ce) scale_q <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         period_q <= '0;
    else if (period_ce) period_q <= wdata;
  end

  always_comb begin
    case (sel)
      SEL_COUNT:  rdata = count_in;
      SEL_SCALE:  rdata = scale_q;
      SEL_PERIOD: rdata = period_q;
      default:    rdata = '0;
    endcase
  end

  assign scale  = scale_q;
  assign period = period_q;
endmodule

// File: rtl/reload_timer.sv
module reload_timer
  import reload_timer_pkg::*;
#(
  parameter int W = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run_en,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [W-1:0]      bus_wdata,
  output logic [W-1:0]      bus_rdata,
  output logic              tick_irq
);
  logic [SYNC_STAGES-1:0] rst_pipe;
  logic                   rst_sync_n;
  logic [W-1:0]           cnt_q, scale_q, period_q, phase_q;
  logic                   cnt_wr, step;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[SYNC_STAGES-2:0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[SYNC_STAGES-1];

  reload_timer_regs #(.W(W)) u_regs (
    .clk(clk), .rst_n(rst_sync_n), .we(bus_we), .addr(bus_addr),
    .wdata(bus_wdata), .count_in(cnt_q), .count_wr(cnt_wr),
    .scale(scale_q), .period(period_q), .rdata(bus_rdata)
  );

  reload_timer_prescaler #(.W(W)) u_pre (
    .clk(clk), .rst_n(rst_sync_n), .run(run_en), .restart(cnt_wr),
    .limit(scale_q), .phase(phase_q), .step(step)
  );

  reload_timer_counter #(.W(W)) u_cnt (
    .clk(clk), .rst_n(rst_sync_n), .step(step), .load_en(cnt_wr),
    .load_val(bus_wdata), .reload_val(period_q), .count(cnt_q),
    .pulse(tick_irq)
  );
endmodule

// File: rtl/reload_timer_chk.sv
module reload_timer_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         run_en,
  input logic         cnt_wr,
  input logic [W-1:0] wdata,
  input logic [W-1:0] cnt,
  input logic [W-1:0] phase,
  input logic [W-1:0] scale,
  input logic [W-1:0] period,
  input logic         irq
);
  assert_step_dec_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (run_en && !cnt_wr && phase >= scale && cnt != '0) |=> (cnt == $past(cnt) - W'(1)));

  assert_hold_between_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (run_en && !cnt_wr && phase < scale) |=> $stable(cnt));

  assert_reload_value_R5: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (cnt == $past(period)));

  assert_pause_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_en && !cnt_wr) |=> ($stable(cnt) && $stable(phase)));

  assert_write_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_wr |=> (cnt == $past(wdata) && phase == '0 && !irq));

  assert_no_irq_paused_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !run_en |=> !irq);
endmodule

bind reload_timer reload_timer_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_sync_n), .run_en(run_en), .cnt_wr(cnt_wr),
  .wdata(bus_wdata), .cnt(cnt_q), .phase(phase_q), .scale(scale_q),
  .period(period_q), .irq(tick_irq)
);

// File: tb/reload_timer_test.sv
module reload_timer_test;
  localparam int CLK_PERIOD = 10;
  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         run_en;
  logic         bus_we;
  logic [1:0]   bus_addr;
  logic [W-1:0] bus_wdata;
  logic [W-1:0] bus_rdata;
  logic         tick_irq;
  int checks = 0;
  int fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  reload_timer uut (
    .clk(clk), .rst_n(rst_n), .run_en(run_en), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .tick_irq(tick_irq)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [W-1:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0; bus_addr = 2'd0;
  endtask

  task automatic rd(input logic [1:0] a, output int v);
    bus_addr = a;
    #1;
    v = int'(bus_rdata);
    bus_addr = 2'd0;
    #1;
  endtask

  task automatic wait_irq(output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!tick_irq && n < 5000);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    int v, n, lim, expc;
    rst_n = 1'b0; run_en = 1'b0; bus_we = 1'b0; bus_addr = 2'd0; bus_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    rd(2'd0, v); chk(v == 0, "R1 count", v, 0);
    rd(2'd1, v); chk(v == 0, "R1 scale", v, 0);
    rd(2'd2, v); chk(v == 0, "R1 period", v, 0);
    chk(tick_irq == 1'b0, "R1 irq", int'(tick_irq), 0);

    // R2 register access
    wr(2'd0, 16'hA5A5); wr(2'd1, 16'h1234); wr(2'd2, 16'hFFFF);
    rd(2'd0, v); chk(v == 'hA5A5, "R2 count", v, 'hA5A5);
    rd(2'd1, v); chk(v == 'h1234, "R2 scale", v, 'h1234);
    rd(2'd2, v); chk(v == 'hFFFF, "R2 period", v, 'hFFFF);
    rd(2'd3, v); chk(v == 0, "R2 unused address", v, 0);

    // R3 R4 R5 sweep over scale and period
    for (int s = 0; s < 4; s++) begin
      for (int p = 0; p < 5; p++) begin
        run_en = 1'b0;
        wr(2'd1, W'(s)); wr(2'd2, W'(p)); wr(2'd0, '0);
        run_en = 1'b1;
        wait_irq(n);
        chk(n == s + 1, (s == 0) ? "R4 first reload" : "R5 first reload", n, s + 1);
        rd(2'd0, v); chk(v == p, "R5 reload value", v, p);
        lim = (p + 1) * (s + 1);
        for (int k = 1; k <= lim; k++) begin
          @(negedge clk);
          expc = (k == lim) ? p : p - k / (s + 1);
          rd(2'd0, v);
          chk(v == expc, (s == 0) ? "R4 count per cycle" : "R3 count per step", v, expc);
          chk(tick_irq == (k == lim), "R5 irq position", int'(tick_irq), int'(k == lim));
        end
      end
    end

    // R6 R9 pause and resume
    run_en = 1'b0;
    wr(2'd1, 16'd3); wr(2'd2, 16'd4); wr(2'd0, 16'd2);
    run_en = 1'b1;
    repeat (5) @(negedge clk);
    run_en = 1'b0;
    rd(2'd0, v); chk(v == 1, "R6 count before pause", v, 1);
    for (int k = 0; k < 10; k++) begin
      @(negedge clk);
      rd(2'd0, v); chk(v == 1, "R6 count held", v, 1);
      chk(tick_irq == 1'b0, "R9 no irq while paused", int'(tick_irq), 0);
    end
    run_en = 1'b1;
    wait_irq(n);
    chk(n == 7, "R6 resume keeps phase", n, 7);

    // R7 count write at a reload step
    run_en = 1'b0;
    wr(2'd1, 16'd0); wr(2'd2, 16'd3); wr(2'd0, 16'd0);
    run_en = 1'b1;
    repeat (4) @(negedge clk);
    rd(2'd0, v); chk(v == 0, "R7 count at zero", v, 0);
    bus_addr = 2'd0; bus_wdata = 16'd5; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
    chk(tick_irq == 1'b0, "R7 write suppresses irq", int'(tick_irq), 0);
    rd(2'd0, v); chk(v == 5, "R7 write wins", v, 5);
    wait_irq(n);
    chk(n == 6, "R7 delay after write", n, 6);

    // R7 prescaler phase restart
    run_en = 1'b0;
    wr(2'd1, 16'd3); wr(2'd0, 16'd4);
    run_en = 1'b1;
    repeat (2) @(negedge clk);
    bus_addr = 2'd0; bus_wdata = 16'd1; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
    rd(2'd0, v); chk(v == 1, "R7 loaded count", v, 1);
    wait_irq(n);
    chk(n == 8, "R7 phase restarted", n, 8);

    // R8 scale shrink below phase
    run_en = 1'b0;
    wr(2'd1, 16'd5); wr(2'd2, 16'd9); wr(2'd0, 16'd3);
    run_en = 1'b1;
    repeat (4) @(negedge clk);
    bus_addr = 2'd1; bus_wdata = 16'd1; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0; bus_addr = 2'd0;
    rd(2'd0, v); chk(v == 3, "R8 old scale at write", v, 3);
    @(negedge clk);
    rd(2'd0, v); chk(v == 2, "R8 immediate step", v, 2);
    @(negedge clk);
    rd(2'd0, v); chk(v == 2, "R8 new scale hold", v, 2);
    @(negedge clk);
    rd(2'd0, v); chk(v == 1, "R8 new scale step", v, 1);
    run_en = 1'b0;

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule